// File: doc/BRIEF.md
# Self-Timed Byte-Write EEPROM Model

This block is a clocked, synthesizable model of a 2048 x 8 electrically erasable memory. Its interface looks like a static RAM. It samples three active-low strobes on a system clock: chip select, output enable and write strobe. It also samples an 11-bit address and a byte of write data. A host reads it like a RAM. For a write, the host pulses the strobes. The block captures the address and data, then becomes busy for a fixed number of clock cycles. During that time it first erases the byte to FFh and then programs the new value.

While the block is busy, a read does not return stored data. It returns a polling byte: bit 7 holds the inverse of the bit 7 being written, and the other bits read as zero. The host can poll bit 7 until it shows the written value.

Two high-voltage flags select special functions. The first flag, together with the top 32 addresses, selects a separate identification store. The second flag, held during a long write-strobe pulse, erases the whole main array. A supply-good input blocks every write while the supply is low, and for a programmable lockout period after the supply returns. All pin inputs pass through a two-stage synchroniser. A read result therefore appears three clock edges after the pins settle.

Top module: `eep_top`

## Requirements
- R1: With chip select and output enable low, write strobe high and the output-enable high-voltage flag clear, `rd_valid` is 1 and `rd_data` carries the byte at `addr`, three clock edges after the pins settle. In every other case, and during reset, `rd_valid` and `rd_data` are 0.
- R2: A byte write is armed when chip select and write strobe are both low and output enable is high. The address is taken when the second of the two strobes goes low. The data is taken when the first of them returns high.
- R3: A write is discarded if output enable goes low at any point while both strobes are low, or if the output-enable high-voltage flag is set.
- R4: After a write is accepted, the block stays busy for `WR_CYC` cycles. It clears the byte to FFh at the midpoint and stores the new value at the end. A read issued late in the busy period still returns the polling byte.
- R5: During any busy period, a read returns the inverse of the pending bit 7 in bit 7, with bits 6..0 equal to 0.
- R6: Write pulses that begin while the block is busy are ignored.
- R7: No write or array clear starts while `supply_ok` is low, or until `LOCK_CYC` cycles after `supply_ok` rises. Reset also starts the lockout.
- R8: When `hv_a9` is set and `addr[10:5]` is all ones, reads and writes go to a separate 32-byte identification store indexed by `addr[4:0]`. That store resets to FFh, and the main array at the same address is untouched.
- R9: Holding chip select and write strobe low with `hv_oe` set for `CLR_CYC` cycles starts an array clear. The clear sweeps every main-array address, one per cycle, in ascending order and writes FFh. A read during the sweep returns 00h.
- R10: A write in which the write strobe falls first and chip select is the pulsed strobe stores data in the same way as a write-strobe-controlled write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| wr_n | input | 1 | Write strobe, active low |
| hv_a9 | input | 1 | High-voltage flag selecting the identification store |
| hv_oe | input | 1 | High-voltage flag on output enable (array clear) |
| supply_ok | input | 1 | Supply above write threshold |
| addr | input | 11 | Byte address |
| wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data or polling byte, 0 when not driven |
| rd_valid | output | 1 | Stands in for the output drivers being enabled |

## Verification
The hardest states to reach are the ones that depend on how the strobes overlap: the address is taken when the later of the two strobes falls, and the data when the earlier one rises. The bench reaches them with hand-built sequences. In these sequences the address changes between the two falling strobes and the data changes between the two rising strobes, so any wrong capture point shows up as a wrong byte at a wrong address. The lockout window after the supply returns is reached by starting a write only a few cycles after `supply_ok` rises.

// File: rtl/eep_pkg.sv
package eep_pkg;
    localparam int ADDR_W   = 11;
    localparam int DATA_W   = 8;
    localparam int DEPTH    = 1 << ADDR_W;
    localparam int ID_AW    = 5;
    localparam int ID_BYTES = 1 << ID_AW;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ERASE,
        PH_PROG,
        PH_SWEEP
    } phase_e;

    typedef struct packed {
        logic              cs_n;
        logic              oe_n;
        logic              wr_n;
        logic              hv_a9;
        logic              hv_oe;
        logic              supply_ok;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } pins_t;

    typedef struct packed {
        logic              en;
        logic              id;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } cell_wr_t;

    function automatic logic id_window(input logic hv, input logic [ADDR_W-1:0] a);
        return hv && (a[ADDR_W-1:ID_AW] == '1);
    endfunction
endpackage

// File: rtl/eep_sync.sv
module eep_sync #(
    parameter int            W       = 1,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/eep_ctrl.sv
module eep_ctrl
    import eep_pkg::*;
#(
    parameter int WR_CYC   = 50000,
    parameter int LOCK_CYC = 250000,
    parameter int CLR_CYC  = 500000
) (
    input  logic              clk,
    input  logic              rst,
    input  pins_t             p,
    output cell_wr_t          wr,
    output logic              busy,
    output logic              sweeping,
    output logic              poll7,
    output logic              unlocked,
    output logic [ADDR_W-1:0] lat_addr,
    output logic [DATA_W-1:0] lat_data
);
    localparam int WR_HALF = (WR_CYC / 2 < 1) ? 1 : WR_CYC / 2;
    localparam int WR_REST = (WR_CYC - WR_HALF < 1) ? 1 : WR_CYC - WR_HALF;
    localparam int TW      = $clog2(WR_CYC + 1);
    localparam int LW      = $clog2(LOCK_CYC + 1);
    localparam int CW      = $clog2(CLR_CYC + 1);

    phase_e            phase;
    logic [TW-1:0]     timer;
    logic [LW-1:0]     lock_cnt;
    logic [CW-1:0]     clr_cnt;
    logic [ADDR_W-1:0] sweep_idx;
    logic              lat_id;
    logic              armed;
    logic              strb_q;

    logic strb_low, strb_rise, strb_fall, oe_ok, clr_cond, erase_end, prog_end;

    always_comb begin
        strb_low  = !p.cs_n && !p.wr_n;
        strb_rise = strb_low && !strb_q;
        strb_fall = !strb_low && strb_q;
        oe_ok     = p.oe_n && !p.hv_oe;
        clr_cond  = strb_low && p.hv_oe;
        unlocked  = p.supply_ok && (lock_cnt == LW'(LOCK_CYC));
        erase_end = (phase == PH_ERASE) && (timer == TW'(WR_HALF - 1));
        prog_end  = (phase == PH_PROG) && (timer == TW'(WR_REST - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            timer     <= '0;
            lock_cnt  <= '0;
            clr_cnt   <= '0;
            sweep_idx <= '0;
            lat_addr  <= '0;
            lat_data  <= '0;
            lat_id    <= 1'b0;
            armed     <= 1'b0;
            strb_q    <= 1'b0;
        end else begin
            strb_q <= strb_low;

            if (!p.supply_ok)
                lock_cnt <= '0;
            else if (lock_cnt != LW'(LOCK_CYC))
                lock_cnt <= lock_cnt + 1'b1;

            if (!clr_cond)
                clr_cnt <= '0;
            else if (clr_cnt != CW'(CLR_CYC))
                clr_cnt <= clr_cnt + 1'b1;

            unique case (phase)
                PH_IDLE: begin
                    if (clr_cond && unlocked && clr_cnt == CW'(CLR_CYC - 1)) begin
                        phase     <= PH_SWEEP;
                        sweep_idx <= '0;
                        lat_data  <= '1;
                        armed     <= 1'b0;
                    end else begin
                        if (strb_rise && oe_ok) begin
                            armed    <= 1'b1;
                            lat_addr <= p.addr;
                            lat_id   <= id_window(p.hv_a9, p.addr);
                        end else if (strb_low && !oe_ok) begin
                            armed <= 1'b0;
                        end
                        if (strb_fall) begin
                            armed <= 1'b0;
                            if (armed && unlocked && oe_ok) begin
                                lat_data <= p.wdata;
                                phase    <= PH_ERASE;
                                timer    <= '0;
                            end
                        end
                    end
                end
                PH_ERASE: begin
                    armed <= 1'b0;
                    if (erase_end) begin
                        phase <= PH_PROG;
                        timer <= '0;
                    end else begin
                        timer <= timer + 1'b1;
                    end
                end
                PH_PROG: begin
                    armed <= 1'b0;
                    if (prog_end) phase <= PH_IDLE;
                    else          timer <= timer + 1'b1;
                end
                PH_SWEEP: begin
                    armed     <= 1'b0;
                    sweep_idx <= sweep_idx + 1'b1;
                    if (sweep_idx == ADDR_W'(DEPTH - 1)) phase <= PH_IDLE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        busy     = (phase != PH_IDLE);
        sweeping = (phase == PH_SWEEP);
        poll7    = ~lat_data[DATA_W-1];
        wr.en    = erase_end || prog_end || sweeping;
        wr.id    = sweeping ? 1'b0 : lat_id;
        wr.addr  = sweeping ? sweep_idx : lat_addr;
        wr.data  = prog_end ? lat_data : '1;
    end
endmodule

// File: rtl/eep_store.sv
module eep_store
    import eep_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  cell_wr_t          wr,
    input  logic              rd_en,
    input  logic              rd_id,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              busy,
    input  logic              poll7,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    logic [DATA_W-1:0] cells [DEPTH];
    logic [DATA_W-1:0] id_cells [ID_BYTES];

    always_ff @(posedge clk) begin
        if (wr.en && !wr.id) cells[wr.addr] <= wr.data;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < ID_BYTES; i++) begin
            if (rst)
                id_cells[i] <= '1;
            else if (wr.en && wr.id && wr.addr[ID_AW-1:0] == ID_AW'(i))
                id_cells[i] <= wr.data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (!rd_en)
                rd_data <= '0;
            else if (busy)
                rd_data <= {poll7, {(DATA_W-1){1'b0}}};
            else if (rd_id)
                rd_data <= id_cells[rd_addr[ID_AW-1:0]];
            else
                rd_data <= cells[rd_addr];
        end
    end
endmodule

// File: rtl/eep_top.sv
module eep_top
    import eep_pkg::*;
#(
    parameter int WR_CYC   = 50000,
    parameter int LOCK_CYC = 250000,
    parameter int CLR_CYC  = 500000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              oe_n,
    input  logic              wr_n,
    input  logic              hv_a9,
    input  logic              hv_oe,
    input  logic              supply_ok,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    localparam int    PW       = $bits(pins_t);
    localparam pins_t PINS_RST = '{cs_n: 1'b1, oe_n: 1'b1, wr_n: 1'b1, default: '0};

    pins_t             raw, s;
    cell_wr_t          cell_wr;
    logic              busy, sweeping, poll7, unlocked;
    logic [ADDR_W-1:0] lat_addr;
    logic [DATA_W-1:0] lat_data;
    logic              rd_en, rd_id;

    always_comb begin
        raw.cs_n      = cs_n;
        raw.oe_n      = oe_n;
        raw.wr_n      = wr_n;
        raw.hv_a9     = hv_a9;
        raw.hv_oe     = hv_oe;
        raw.supply_ok = supply_ok;
        raw.addr      = addr;
        raw.wdata     = wdata;
    end

    eep_sync #(.W(PW), .RST_VAL(PINS_RST)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (s)
    );

    eep_ctrl #(.WR_CYC(WR_CYC), .LOCK_CYC(LOCK_CYC), .CLR_CYC(CLR_CYC)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .p        (s),
        .wr       (cell_wr),
        .busy     (busy),
        .sweeping (sweeping),
        .poll7    (poll7),
        .unlocked (unlocked),
        .lat_addr (lat_addr),
        .lat_data (lat_data)
    );

    always_comb begin
        rd_en = !s.cs_n && !s.oe_n && s.wr_n && !s.hv_oe;
        rd_id = id_window(s.hv_a9, s.addr);
    end

    eep_store u_store (
        .clk      (clk),
        .rst      (rst),
        .wr       (cell_wr),
        .rd_en    (rd_en),
        .rd_id    (rd_id),
        .rd_addr  (s.addr),
        .busy     (busy),
        .poll7    (poll7),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );
endmodule

// File: rtl/eep_chk.sv
module eep_chk (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        sweeping,
    input logic        unlocked,
    input logic [10:0] lat_addr,
    input logic [7:0]  lat_data,
    input logic        wr_en,
    input logic [10:0] wr_addr,
    input logic [7:0]  rd_data,
    input logic        rd_valid
);
    // R1
    idle_out_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |-> rd_data == 8'h00);

    // R5
    poll_low_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid && $past(busy) |-> rd_data[6:0] == 7'h00);

    // R4
    latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy && $past(busy) |-> $stable(lat_addr) && $stable(lat_data));

    // R7
    lockout_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(unlocked));

    // R9
    sweep_step_chk: assert property (@(posedge clk) disable iff (rst)
        sweeping && $past(sweeping) |-> wr_addr == 11'($past(wr_addr) + 11'd1));

    // R9
    sweep_write_chk: assert property (@(posedge clk) disable iff (rst)
        sweeping |-> wr_en);
endmodule

bind eep_top eep_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .sweeping (sweeping),
    .unlocked (unlocked),
    .lat_addr (lat_addr),
    .lat_data (lat_data),
    .wr_en    (cell_wr.en),
    .wr_addr  (cell_wr.addr),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
);

// File: tb/test_eep_top.sv
module test_eep_top;
    localparam int CLK_PERIOD = 10;
    localparam int WR_CYC     = 40;
    localparam int LOCK_CYC   = 100;
    localparam int CLR_CYC    = 50;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1, oe_n = 1'b1, wr_n = 1'b1;
    logic        hv_a9 = 1'b0, hv_oe = 1'b0, supply_ok = 1'b1;
    logic [10:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rd_data;
    logic        rd_valid;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [7:0] data;
        logic       valid;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    event sample_ev;

    always #(CLK_PERIOD/2) clk = ~clk;

    eep_top #(.WR_CYC(WR_CYC), .LOCK_CYC(LOCK_CYC), .CLR_CYC(CLR_CYC)) i_eep_top (
        .clk(clk), .rst(rst), .cs_n(cs_n), .oe_n(oe_n), .wr_n(wr_n),
        .hv_a9(hv_a9), .hv_oe(hv_oe), .supply_ok(supply_ok),
        .addr(addr), .wdata(wdata), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    // monitor: pops one expected item per sample event
    initial begin
        forever begin
            @(sample_ev);
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (rd_data !== e.data || rd_valid !== e.valid) begin
                    errors++;
                    $display("FAIL %s: got data=%02h valid=%0b, expected data=%02h valid=%0b",
                             e.tag, rd_data, rd_valid, e.data, e.valid);
                end
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_now(input logic [7:0] d, input logic v, input string tag);
        exp_t e;
        e.data = d; e.valid = v; e.tag = tag;
        exp_q.push_back(e);
        -> sample_ev;
        #1;
    endtask

    task automatic rd(input logic [10:0] a, input logic hv, input logic [7:0] d, input string tag);
        @(negedge clk);
        addr = a; hv_a9 = hv; hv_oe = 1'b0;
        cs_n = 1'b0; oe_n = 1'b0; wr_n = 1'b1;
        cyc(4);
        expect_now(d, 1'b1, tag);
        cs_n = 1'b1; oe_n = 1'b1; hv_a9 = 1'b0;
        cyc(4);
    endtask

    task automatic wr(input logic [10:0] a, input logic [7:0] d, input logic hv);
        @(negedge clk);
        addr = a; wdata = d; hv_a9 = hv; oe_n = 1'b1; cs_n = 1'b0;
        cyc(1);
        wr_n = 1'b0;
        cyc(3);
        wr_n = 1'b1;
        cyc(2);
        cs_n = 1'b1;
        cyc(3);
        hv_a9 = 1'b0;
    endtask

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(1);
        // R1 reset state of the outputs
        expect_now(8'h00, 1'b0, "R1 reset");
        cyc(LOCK_CYC + 20);

        // R9 array clear
        @(negedge clk);
        cs_n = 1'b0; oe_n = 1'b1; hv_oe = 1'b1; wr_n = 1'b0;
        cyc(CLR_CYC + 10);
        wr_n = 1'b1; cs_n = 1'b1; hv_oe = 1'b0;
        rd(11'h000, 1'b0, 8'h00, "R9 poll during sweep");
        cyc(2100);
        rd(11'h000, 1'b0, 8'hFF, "R9 first");
        rd(11'h7FF, 1'b0, 8'hFF, "R9 last");
        rd(11'h155, 1'b0, 8'hFF, "R9 middle");

        // R1 output enable high keeps outputs off
        @(negedge clk);
        addr = 11'h000; cs_n = 1'b0; oe_n = 1'b1; wr_n = 1'b1;
        cyc(4);
        expect_now(8'h00, 1'b0, "R1 oe high");
        cs_n = 1'b1;
        cyc(3);

        // R2 R5 R4 write with bit7 = 0
        wr(11'h123, 8'h5A, 1'b0);
        rd(11'h123, 1'b0, 8'h80, "R5 poll bit7=0");
        cyc(WR_CYC);
        rd(11'h123, 1'b0, 8'h5A, "R2 data stored");

        // R5 R4 write with bit7 = 1, late poll
        wr(11'h124, 8'hC3, 1'b0);
        cyc(WR_CYC - 26);
        rd(11'h124, 1'b0, 8'h00, "R4 late poll");
        cyc(WR_CYC);
        rd(11'h124, 1'b0, 8'hC3, "R4 after cycle");

        // R6 second write during busy ignored
        wr(11'h200, 8'h11, 1'b0);
        wr(11'h201, 8'h22, 1'b0);
        cyc(WR_CYC + 5);
        rd(11'h200, 1'b0, 8'h11, "R6 first write");
        rd(11'h201, 1'b0, 8'hFF, "R6 ignored write");

        // R3 output enable dropped mid-pulse
        @(negedge clk);
        addr = 11'h300; wdata = 8'h33; oe_n = 1'b1; cs_n = 1'b0; wr_n = 1'b0;
        cyc(3); oe_n = 1'b0; cyc(2); oe_n = 1'b1; cyc(2);
        wr_n = 1'b1; cs_n = 1'b1;
        cyc(WR_CYC + 5);
        rd(11'h300, 1'b0, 8'hFF, "R3 oe low inhibit");

        // R3 high-voltage output enable short pulse
        @(negedge clk);
        addr = 11'h301; wdata = 8'h34; oe_n = 1'b1; hv_oe = 1'b1; cs_n = 1'b0; wr_n = 1'b0;
        cyc(5);
        wr_n = 1'b1; cs_n = 1'b1; hv_oe = 1'b0;
        cyc(WR_CYC + 5);
        rd(11'h301, 1'b0, 8'hFF, "R3 hv_oe inhibit");

        // R10 chip-select controlled write
        @(negedge clk);
        addr = 11'h310; wdata = 8'h77; oe_n = 1'b1; wr_n = 1'b0;
        cyc(2); cs_n = 1'b0; cyc(3); cs_n = 1'b1; cyc(2); wr_n = 1'b1;
        cyc(WR_CYC + 5);
        rd(11'h310, 1'b0, 8'h77, "R10 cs controlled");

        // R2 address at later fall, data at earlier rise
        @(negedge clk);
        addr = 11'h320; wdata = 8'h9C; oe_n = 1'b1; cs_n = 1'b0;
        cyc(3); addr = 11'h321; cyc(3); wr_n = 1'b0;
        cyc(3); wr_n = 1'b1; cyc(3); wdata = 8'h3E; cyc(3); cs_n = 1'b1;
        cyc(WR_CYC + 5);
        rd(11'h321, 1'b0, 8'h9C, "R2 capture points");
        rd(11'h320, 1'b0, 8'hFF, "R2 early address unused");

        // R8 identification store
        wr(11'h7E3, 8'hA5, 1'b1);
        cyc(WR_CYC + 5);
        rd(11'h7E3, 1'b1, 8'hA5, "R8 id written");
        rd(11'h7E3, 1'b0, 8'hFF, "R8 main untouched");
        rd(11'h7E4, 1'b1, 8'hFF, "R8 id reset value");

        // R7 supply low and lockout
        @(negedge clk); supply_ok = 1'b0; cyc(3);
        wr(11'h400, 8'h44, 1'b0);
        cyc(WR_CYC + 5);
        @(negedge clk); supply_ok = 1'b1;
        wr(11'h401, 8'h45, 1'b0);
        cyc(WR_CYC + 5);
        cyc(LOCK_CYC);
        wr(11'h402, 8'h46, 1'b0);
        cyc(WR_CYC + 5);
        rd(11'h400, 1'b0, 8'hFF, "R7 supply low");
        rd(11'h401, 1'b0, 8'hFF, "R7 lockout");
        rd(11'h402, 1'b0, 8'h46, "R7 after lockout");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule